// File: doc/BRIEF.md
# Far-End Alarm Code Validator

This block watches the far-end alarm-and-control bit channel that the DS3 receive path pulls out of each incoming frame, one bit per strobe. It hunts for the byte 01111110. Once that byte is found, it takes the next six bits as a code word. The block then goes back to hunting.

Every captured code goes into a ten-deep window of recent receptions. After each capture, the block counts how many entries in that window match the newest code.
- **Validation:** when no code is currently valid and a code fills eight of the ten slots, that code becomes the valid code.
- **Removal:** while a code is valid, if a different code reaches three of the ten slots, the valid code is withdrawn.

Each event sets its own sticky status flag. The flags clear on read. A single interrupt line combines the flags, each one gated by its own enable.

Software uses a four-word register port:
- address 0: enables
- address 1: status
- address 2: validated code
- address 3: last captured code

Top module: `feac_validator`

## Requirements
- R1: No code is captured until the exact bit sequence 0,1,1,1,1,1,1,0 has arrived on consecutive strobes. Register 3 (bits 5:0, the last captured code) changes only on a capture.
- R2: The six bits after the alignment byte form the code. The first bit received is bit 5. The code is written to register 3 on the strobe that delivers the sixth bit.
- R3: While no code is valid, a reception whose code fills at least 8 of the last 10 window slots causes three updates one clock after that capture: status bit 0 (validation flag) is set, status bit 2 (code-valid) is set, and register 2 (bits 5:0) takes the code.
- R4: Further receptions of the code that is currently valid raise no new validation flag.
- R5: While a code is valid, a reception of a different code that fills at least 3 of the last 10 slots has two effects: status bit 1 (removal flag) is set and status bit 2 is cleared. Receptions older than the last ten are not counted.
- R6: Status bits 0 and 1 stay set until status (address 1) is read. They read as set on that access and as clear afterwards. The read does not change bit 2.
- R7: Register 0 bit 0 enables the validation interrupt and bit 1 enables the removal interrupt. `irq` is high exactly when a set flag has its enable set.
- R8: After a capture the block needs a complete new alignment byte before it captures again. The code bits are never taken as part of an alignment byte.
- R9: After reset, all registers read zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | Strobe: one channel bit this cycle |
| bit_dat | input | 1 | Channel bit value |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status on address 1) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters:
- a six-bit code
- a ten-deep window
- thresholds of eight and three

With these values, a validation takes eight words and a removal three. A full window turnover therefore fits in a few hundred strobes. This brings every edge within reach:
- the seventh and eighth matching reception
- a third differing code that does or does not fall inside the window
- a near-miss alignment byte
- bits that arrive straight after a capture

// File: rtl/feac_validator.sv
module feac_validator #(
  parameter int CW     = 6,
  parameter int DEPTH  = 10,
  parameter int VAL_TH = 8,
  parameter int REM_TH = 3,
  parameter logic [7:0] ALIGN = 8'h7E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_vld,
  input  logic       bit_dat,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int NW = $clog2(DEPTH + 1);
  localparam int BW = $clog2(CW + 1);

  logic          hunting, eval;
  logic [7:0]    align_sr;
  logic [BW-1:0] bcnt;
  logic [CW-1:0] shf, last_code, vcode;
  logic [CW-1:0] hist [DEPTH];
  logic [DEPTH-1:0] hist_v;
  logic [PW-1:0] wptr;
  logic          code_ok, val_sts, rem_sts, val_en, rem_en;
  logic [NW-1:0] hits;

  wire [7:0]    align_nx = {align_sr[6:0], bit_dat};
  wire [CW-1:0] code_nx  = {shf[CW-2:0], bit_dat};
  wire          push     = bit_vld && !hunting && bcnt == BW'(CW - 1);
  wire          sts_rd   = reg_rd && reg_addr == 2'd1;
  wire          unused_wdata = &{1'b0, reg_wdata[7:2]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hunting   <= 1'b1;
      align_sr  <= '0;
      bcnt      <= '0;
      shf       <= '0;
      last_code <= '0;
      wptr      <= '0;
      hist_v    <= '0;
      eval      <= 1'b0;
    end else begin
      eval <= push;
      if (bit_vld) begin
        if (hunting) begin
          align_sr <= align_nx;
          if (align_nx == ALIGN) begin
            hunting <= 1'b0;
            bcnt    <= '0;
          end
        end else begin
          shf  <= code_nx;
          bcnt <= bcnt + BW'(1);
          if (push) begin
            hunting      <= 1'b1;
            align_sr     <= '0;
            last_code    <= code_nx;
            hist_v[wptr] <= 1'b1;
            wptr         <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + PW'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk)
    if (push) hist[wptr] <= code_nx;

  always_comb begin
    hits = '0;
    for (int i = 0; i < DEPTH; i++)
      if (hist_v[i] && hist[i] == last_code) hits = hits + NW'(1);
  end

  wire fire_val = eval && !code_ok && hits >= NW'(VAL_TH);
  wire fire_rem = eval && code_ok && last_code != vcode && hits >= NW'(REM_TH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_ok <= 1'b0;
      vcode   <= '0;
      val_sts <= 1'b0;
      rem_sts <= 1'b0;
      val_en  <= 1'b0;
      rem_en  <= 1'b0;
    end else begin
      if (fire_val) begin
        code_ok <= 1'b1;
        vcode   <= last_code;
      end
      if (fire_rem) code_ok <= 1'b0;
      val_sts <= fire_val | (val_sts & ~sts_rd);
      rem_sts <= fire_rem | (rem_sts & ~sts_rd);
      if (reg_wr && reg_addr == 2'd0) {rem_en, val_en} <= reg_wdata[1:0];
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {6'b0, rem_en, val_en};
      2'd1:    reg_rdata = {5'b0, code_ok, rem_sts, val_sts};
      2'd2:    reg_rdata = {{(8 - CW){1'b0}}, vcode};
      default: reg_rdata = {{(8 - CW){1'b0}}, last_code};
    endcase
  end

  assign irq = (val_sts & val_en) | (rem_sts & rem_en);

  p_code_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !push |=> $stable(last_code));
  p_rehunt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> hunting && align_sr == 8'h00);
  p_validate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire_val |=> code_ok && val_sts && vcode == $past(last_code));
  p_remove_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire_rem |=> !code_ok && rem_sts);
  p_clear_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sts_rd && !eval |=> !val_sts && !rem_sts && code_ok == $past(code_ok));
  p_irq_val_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(val_sts) && val_en |-> irq);
endmodule

// File: tb/feac_validator_tb.sv
`timescale 1ns/1ps
module feac_validator_tb_top;
  logic clk = 0, rst_n = 0, bit_vld = 0, bit_dat = 0, reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  feac_validator dut_i (.clk, .rst_n, .bit_vld, .bit_dat, .reg_wr, .reg_rd,
                        .reg_addr, .reg_wdata, .reg_rdata, .irq);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic send_bit(bit b);
    @(negedge clk) begin bit_vld = 1; bit_dat = b; end
    @(negedge clk) bit_vld = 0;
  endtask

  task automatic send_raw(logic [7:0] v, int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic send_word(logic [5:0] c);
    send_raw(8'h7E, 8);
    send_raw({2'b0, c}, 6);
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk) begin reg_wr = 1; reg_addr = a; reg_wdata = d; end
    @(negedge clk) reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    @(negedge clk) begin reg_rd = 1; reg_addr = a; end
    #1 v = reg_rdata;
    @(negedge clk) reg_rd = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset();
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R9 register after reset", v, 0);
    end
    chk("R9 irq after reset", irq, 0);
  endtask

  task automatic t_hunt();
    logic [7:0] v;
    do_reset();
    send_raw(8'h7F, 8);
    send_raw(8'h2A, 6);
    repeat (3) @(negedge clk);
    rd(2'd3, v);
    chk("R1 near-miss alignment captures nothing", v, 0);
  endtask

  task automatic t_capture();
    logic [7:0] v;
    do_reset();
    send_word(6'h2D);
    rd(2'd3, v);
    chk("R2 code msb first", v, 8'h2D);
    send_word(6'h12);
    rd(2'd3, v);
    chk("R2 second code", v, 8'h12);
  endtask

  task automatic t_validate();
    logic [7:0] v;
    do_reset();
    wr(2'd0, 8'h01);
    repeat (7) send_word(6'h15);
    rd(2'd1, v);
    chk("R3 seven matches not enough", v, 0);
    chk("R3 irq low before validation", irq, 0);
    send_word(6'h15);
    chk("R7 irq on validation", irq, 1);
    rd(2'd1, v);
    chk("R3 validation status", v, 8'h05);
    rd(2'd2, v);
    chk("R3 validated code", v, 8'h15);
    rd(2'd1, v);
    chk("R6 flag cleared by read, valid kept", v, 8'h04);
    chk("R6 irq low after read", irq, 0);
    send_word(6'h15);
    rd(2'd1, v);
    chk("R4 no repeat validation", v, 8'h04);
  endtask

  task automatic t_remove();
    logic [7:0] v;
    do_reset();
    wr(2'd0, 8'h03);
    repeat (8) send_word(6'h15);
    rd(2'd1, v);
    repeat (2) send_word(6'h3F);
    rd(2'd1, v);
    chk("R5 two differing codes not enough", v, 8'h04);
    chk("R7 irq low before removal", irq, 0);
    send_word(6'h3F);
    chk("R7 irq on removal", irq, 1);
    rd(2'd1, v);
    chk("R5 removal status", v, 8'h02);
    rd(2'd1, v);
    chk("R6 removal flag cleared", v, 0);
  endtask

  task automatic t_window();
    logic [7:0] v;
    do_reset();
    repeat (2) send_word(6'h3F);
    repeat (8) send_word(6'h15);
    rd(2'd1, v);
    chk("R3 validation with older entries", v, 8'h05);
    send_word(6'h3F);
    rd(2'd1, v);
    chk("R5 aged entry not counted", v, 8'h04);
  endtask

  task automatic t_gate();
    logic [7:0] v;
    do_reset();
    repeat (8) send_word(6'h09);
    chk("R7 irq masked", irq, 0);
    wr(2'd0, 8'h02);
    chk("R7 wrong enable keeps irq low", irq, 0);
    wr(2'd0, 8'h01);
    chk("R7 enable exposes pending flag", irq, 1);
    rd(2'd0, v);
    chk("R7 enable readback", v, 8'h01);
  endtask

  task automatic t_rehunt();
    logic [7:0] v;
    do_reset();
    send_word(6'h2A);
    send_raw(8'h11, 6);
    repeat (3) @(negedge clk);
    rd(2'd3, v);
    chk("R8 no capture without new alignment", v, 8'h2A);
    send_word(6'h07);
    rd(2'd3, v);
    chk("R8 capture after fresh alignment", v, 8'h07);
  endtask

  initial begin
    t_reset();
    t_hunt();
    t_capture();
    t_validate();
    t_remove();
    t_window();
    t_gate();
    t_rehunt();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule